// File: doc/BRIEF.md
# I2C SCL Rate Divider

This block produces the bit timing for an I2C master's clock line. A peripheral clock first passes through a small prescaler. The prescaler emits one internal tick every 1 + CDF clocks. A period counter then sets the length of each SCL cycle in ticks. That length is a base of 20, plus 8 times a coarse divider, plus a compensation term R. R covers line rise time, fall time and internal delay, in whole ticks. The period is split into a low half and a high half, and an odd tick goes to the low half.

The byte engine uses the block's outputs. `scl_toggle` marks the tick that ends each phase. `sda_chg` marks the middle of a low phase, where SDA may change. `sda_smp` marks the middle of a high phase, where SDA is sampled. `first_bit` marks the moment the first data bit may be driven, counted from the start condition.

Software works out the divider fields and places them on the configuration pins. The block copies them only when `start` is pulsed, so a running transfer never sees a change. All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `scl_rate_divider`

## Requirements
- R1: After reset, and from a few cycles after `halt`, `scl_out` is 1 and `scl_toggle`, `sda_chg`, `sda_smp` and `first_bit` stay 0.
- R2: Internal ticks occur once every 1 + CDF clocks, where CDF is `cfg_div[2:0]`. The first tick falls CDF clocks after the edge that samples `start`.
- R3: One SCL period is P = 20 + 8·SCGD + R ticks, where SCGD is `cfg_div[8:3]` and R is `cfg_rise`.
- R4: The low phase lasts ceil(P/2) ticks and the high phase lasts floor(P/2) ticks. SCL goes low at the edge that samples `start`. `scl_toggle` is high for one cycle on the tick that ends a phase, and `scl_out` inverts at the next edge.
- R5: `sda_chg` pulses on the tick with index floor(low/2) of each low phase, counted from 0, while `scl_out` is 0. `sda_smp` pulses on the tick with index floor(high/2) of each high phase, while `scl_out` is 1.
- R6: `first_bit` pulses exactly once per start, on tick number `cfg_setup` + 2 after the start. The code 15 gives 17 ticks.
- R7: The configuration pins are captured only on a `start` pulse. Changes to them at any other time have no effect on timing.
- R8: A `start` while the block is running restarts all timing at once with the newly captured configuration. If `start` and `halt` arrive together, `start` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle start condition; captures configuration and begins timing |
| halt | input | 1 | One-cycle request to stop and return SCL high |
| cfg_div | input | 9 | Divider fields: [2:0] prescale CDF, [8:3] coarse divider SCGD |
| cfg_rise | input | 6 | Rise/fall compensation R in ticks |
| cfg_setup | input | 4 | First-bit setup code; delay is code + 2 ticks |
| scl_out | output | 1 | SCL level |
| scl_toggle | output | 1 | Pulse on the tick that ends an SCL phase |
| sda_chg | output | 1 | Mid-low strobe for changing SDA |
| sda_smp | output | 1 | Mid-high strobe for sampling SDA |
| first_bit | output | 1 | Pulse marking the end of first-bit setup |

## Verification
The bench targets several timing corners.

- **Odd periods.** It runs odd and even periods, including the minimum period of 20 ticks. A design that rounds the odd tick into the high phase would show swapped interval lengths.
- **Prescale extremes.** It uses prescale values of 0 and 7. An off-by-one in the prescaler would stretch every interval by a whole phase length.
- **Configuration stability.** It changes the configuration pins in the middle of a run. A design that reads the pins live would change interval lengths without a new start.
- **Restart without halt.** It restarts while running. A design that kept its old counters would misplace the first toggle and the first-bit pulse after the restart.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  parameter int CDF_W      = 3;
  parameter int SCGD_W     = 6;
  parameter int RISE_W     = 6;
  parameter int SETUP_W    = 4;
  parameter int BASE_TICKS = 20;
  parameter int STEP_TICKS = 8;
  parameter int SETUP_BIAS = 2;
  parameter int DIV_W      = CDF_W + SCGD_W;
  parameter int PER_MAX    = BASE_TICKS + STEP_TICKS * (2**SCGD_W - 1) + (2**RISE_W - 1);
  parameter int PER_W      = $clog2(PER_MAX + 1);
  parameter int TGT_W      = SETUP_W + 1;

  typedef struct packed {
    logic [CDF_W-1:0]   cdf;
    logic [SCGD_W-1:0]  scgd;
    logic [RISE_W-1:0]  rise;
    logic [SETUP_W-1:0] setup;
  } div_cfg_t;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler
  import scl_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             active,
  input  logic [CDF_W-1:0] cdf_max,
  output logic             tick
);
  logic [CDF_W-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc_q <= '0;
    else if (restart)  pc_q <= '0;
    else if (active)   pc_q <= (pc_q == cdf_max) ? '0 : pc_q + CDF_W'(1);
  end

  assign tick = active && !restart && (pc_q == cdf_max);

  // two ticks never sit back to back unless the prescale is 1
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cdf_max != '0 && !restart) |=> !tick);
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             active,
  input  logic             tick,
  input  logic [PER_W-1:0] period,
  output logic             scl_out,
  output logic             scl_toggle,
  output logic             sda_chg,
  output logic             sda_smp
);
  logic [PER_W-1:0] low_len, high_len, cur_len, tc_q;
  logic             scl_q, at_end;

  assign low_len  = (period + PER_W'(1)) >> 1;
  assign high_len = period >> 1;
  assign cur_len  = scl_q ? high_len : low_len;
  assign at_end   = (tc_q == cur_len - PER_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      tc_q  <= '0;
    end else if (restart) begin
      scl_q <= 1'b0;
      tc_q  <= '0;
    end else if (!active) begin
      scl_q <= 1'b1;
      tc_q  <= '0;
    end else if (tick) begin
      tc_q <= at_end ? '0 : tc_q + PER_W'(1);
      if (at_end) scl_q <= ~scl_q;
    end
  end

  assign scl_out    = scl_q;
  assign scl_toggle = tick && at_end;
  assign sda_chg    = tick && !scl_q && (tc_q == (low_len >> 1));
  assign sda_smp    = tick &&  scl_q && (tc_q == (high_len >> 1));

  p_toggle_flips_r4: assert property (@(posedge clk) disable iff (!rst_n)
    scl_toggle |=> (scl_out != $past(scl_out)));
  p_chg_in_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_chg && !restart) |=> !scl_out);
  p_smp_in_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_smp && active && !restart) |=> scl_out);
endmodule

// File: rtl/scl_setup_delay.sv
module scl_setup_delay
  import scl_div_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               tick,
  input  logic [SETUP_W-1:0] setup_code,
  output logic               first_bit
);
  logic [TGT_W-1:0] target, cnt_q;
  logic             pend_q, hit;

  assign target = TGT_W'(setup_code) + TGT_W'(SETUP_BIAS);
  assign hit    = (cnt_q == target - TGT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      pend_q <= 1'b1;
    end else if (tick && pend_q) begin
      if (hit) pend_q <= 1'b0;
      else     cnt_q  <= cnt_q + TGT_W'(1);
    end
  end

  assign first_bit = tick && pend_q && hit;

  p_fb_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (first_bit && !restart) |=> !first_bit);
endmodule

// File: rtl/scl_rate_divider.sv
module scl_rate_divider
  import scl_div_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               halt,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [RISE_W-1:0]  cfg_rise,
  input  logic [SETUP_W-1:0] cfg_setup,
  output logic               scl_out,
  output logic               scl_toggle,
  output logic               sda_chg,
  output logic               sda_smp,
  output logic               first_bit
);
  div_cfg_t         cfg_q;
  logic             active_q, tick;
  logic [PER_W-1:0] period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cfg_q    <= '0;
    end else if (start) begin
      active_q    <= 1'b1;
      cfg_q.cdf   <= cfg_div[CDF_W-1:0];
      cfg_q.scgd  <= cfg_div[DIV_W-1:CDF_W];
      cfg_q.rise  <= cfg_rise;
      cfg_q.setup <= cfg_setup;
    end else if (halt) begin
      active_q <= 1'b0;
    end
  end

  assign period = PER_W'(BASE_TICKS) + PER_W'(STEP_TICKS) * PER_W'(cfg_q.scgd)
                + PER_W'(cfg_q.rise);

  scl_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .restart(start), .active(active_q),
    .cdf_max(cfg_q.cdf), .tick(tick)
  );

  scl_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n), .restart(start), .active(active_q), .tick(tick),
    .period(period), .scl_out(scl_out), .scl_toggle(scl_toggle),
    .sda_chg(sda_chg), .sda_smp(sda_smp)
  );

  scl_setup_delay u_setup (
    .clk(clk), .rst_n(rst_n), .restart(start), .tick(tick),
    .setup_code(cfg_q.setup), .first_bit(first_bit)
  );

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(cfg_q));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (!scl_toggle && !sda_chg && !sda_smp && !first_bit));
endmodule

// File: tb/tb_scl_rate_divider.sv
module tb_scl_rate_divider;
  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0, halt = 1'b0;
  logic [8:0] cfg_div = '0;
  logic [5:0] cfg_rise = '0;
  logic [3:0] cfg_setup = '0;
  logic       scl_out, scl_toggle, sda_chg, sda_smp, first_bit;

  scl_rate_divider dut (
    .clk(clk), .rst_n(rst_n), .start(start), .halt(halt), .cfg_div(cfg_div),
    .cfg_rise(cfg_rise), .cfg_setup(cfg_setup), .scl_out(scl_out),
    .scl_toggle(scl_toggle), .sda_chg(sda_chg), .sda_smp(sda_smp),
    .first_bit(first_bit)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int q[$];
  int n_chk = 0, n_pass = 0;
  int exp_low, exp_high, exp_d, exp_fb, last, c0;
  bit mon_low, fb_seen, run = 1'b0, done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (ok) n_pass++;
    else $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_pass, n_chk);
      $finish;
    end
  endtask

  // monitor: pops expected intervals and checks strobes
  always @(negedge clk) if (rst_n) begin
    if (run && sda_chg)
      check(mon_low && (cyc - last == (exp_low/2 + 1) * exp_d), "R5", "sda_chg offset",
            cyc - last, (exp_low/2 + 1) * exp_d);
    if (run && sda_smp)
      check(!mon_low && (cyc - last == (exp_high/2 + 1) * exp_d), "R5", "sda_smp offset",
            cyc - last, (exp_high/2 + 1) * exp_d);
    if (run && first_bit) begin
      check(!fb_seen && (cyc == c0 - 1 + exp_fb * exp_d), "R6", "first_bit cycle",
            cyc - c0 + 1, exp_fb * exp_d);
      fb_seen = 1'b1;
    end
    if (run && scl_toggle) begin
      if (q.size() > 0) begin
        int e;
        e = q.pop_front();
        check(cyc - last == e, "R2,R3,R4", "phase length", cyc - last, e);
      end
      last = cyc;
      mon_low = !mon_low;
    end
    if (start) begin
      last = cyc; c0 = cyc + 1; mon_low = 1'b1; fb_seen = 1'b0; run = 1'b1;
    end else if (halt) run = 1'b0;
  end

  // driver: computes expectations and launches a run
  task automatic launch(input int cdf, input int scgd, input int rise,
                        input int setup, input int nph);
    int p;
    @(posedge clk); #2;
    p = 20 + 8 * scgd + rise;
    exp_low = (p + 1) / 2; exp_high = p / 2; exp_d = cdf + 1; exp_fb = setup + 2;
    for (int i = 0; i < nph; i++) q.push_back(((i % 2) == 0 ? exp_low : exp_high) * exp_d);
    cfg_div = 9'((scgd << 3) | cdf); cfg_rise = 6'(rise); cfg_setup = 4'(setup);
    start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(posedge clk);
    @(posedge clk); #2;
  endtask

  task automatic idle_check(input string req);
    int bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!scl_out || scl_toggle || sda_chg || sda_smp || first_bit) bad++;
    end
    check(bad == 0, req, "idle cycles with activity", bad, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle_check("R1");                      // reset state

    launch(0, 0, 0, 15, 6);                // R3 minimum period, R6 code 15 -> 17 ticks
    drain();
    check(fb_seen, "R6", "first_bit seen", fb_seen, 1);

    launch(3, 2, 5, 0, 6);                 // R2 prescale 4, R4 odd period 41
    drain();
    check(fb_seen, "R6", "first_bit seen", fb_seen, 1);

    launch(7, 1, 3, 5, 5);                 // R2 prescale 8, odd period 31
    repeat (5) @(posedge clk);
    #2 cfg_div = {6'd20, 3'd0}; cfg_rise = 6'd40; cfg_setup = 4'd3;  // R7 ignored
    drain();
    check(fb_seen, "R7", "first_bit kept old setup", fb_seen, 1);

    launch(1, 0, 1, 2, 4);                 // R8 restart while running, period 21
    drain();
    check(fb_seen, "R8", "first_bit after restart", fb_seen, 1);

    halt = 1'b1; @(posedge clk); #2 halt = 1'b0;
    repeat (3) @(posedge clk);
    idle_check("R1");
    check(q.size() == 0, "R4", "queue drained", q.size(), 0);
    finish_run();
  end
endmodule